// File: doc/BRIEF.md
# Board-Trace RAM Line Self-Test Engine

This engine takes over a byte-wide synchronous SRAM port after a start pulse. It steps through a fixed list of phases aimed at the copper between the controller and the memory rather than at the memory cells. The address bus and the data bus each get a walking-zero and a walking-one sweep, so every trace is toggled on its own. The address bus also swings between all-zeros and all-ones. A bridging pass gives every location its own value, so lines shorted together or left open alias visibly. Fill passes set the whole array to ones and clear it back, checking each location.

Every value the engine writes is later read back and compared. At the first disagreement the engine stops and keeps a snapshot: a phase code, the address, the byte it expected and the byte it read. An optional burst at location zero flips the data bus between 0x00 and 0xFF on consecutive cycles and then checks that the location ended at zero. After a clean run the array holds all zeros.

Top module: `ram_line_bist`

## Requirements
- R1: After reset, busy, done, pass, fail and mem_we are all 0.
- R2: A start seen while idle begins a run, and busy stays 1 until the run ends. The toggle-burst enable is sampled at that start. A start seen while busy has no effect on the run's sequence or length.
- R3: The run opens with two address sweeps, and every write in them is read back at the same address on the next cycle. The first sweep writes 0x55 to addresses with a single 0 bit, moving that bit from bit 0 to bit AW-1. The second writes 0xAA to addresses with a single 1 bit, in the same order.
- R4: The address sweeps are followed by writes of 0x55 to all-ones, all-zeros and all-ones, then 0xAA to all-zeros. Each write is read back.
- R5: Bridging: the engine writes value (a+1) mod 256 to every address a in ascending order with no read in between. It then reads all addresses in ascending order and checks them.
- R6: Data sweeps at address 0: single-0 bytes from bit 0 upward, then single-1 bytes from bit 0 upward, each write read back.
- R7: The engine then clears the whole array without reads. Next it writes 0xFF to each location and reads it back, and then writes 0x00 to each location and reads it back. A clean run leaves every location 0x00.
- R8: With the burst enabled, the engine writes TOG_WRITES (odd) bytes to address 0 on consecutive cycles, 0x00 at even positions and 0xFF at odd positions. It then reads address 0 back expecting 0x00.
- R9: On the first read that differs from its expected byte, the run stops and fail=1, pass=0. The engine latches the phase code (0/1 address sweeps, 2 rise, 3 fall, 4 bridge write, 5 bridge read, 6/7 data sweeps, 8 clear, 9 set, 10 clear-check, 11 burst, 12 burst check), the address, the expected byte and the read byte. These stay held until the next start.
- R10: done is a single-cycle pulse at the end of every run, pass or fail. A clean run raises pass. Without the burst a clean run's done comes 2·(2AW+4+2DW+2·2^AW)+3·2^AW+2 cycles after the start edge; the burst adds TOG_WRITES+1 cycles.
- R11: The memory returns read data on the cycle after the address, and the engine compares it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| tog_en | input | 1 | Enable the 0x00/0xFF burst phase |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run finished with no mismatch |
| fail | output | 1 | Last run stopped on a mismatch |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read data, one cycle latency |
| err_phase | output | 4 | Phase code of the first mismatch |
| err_addr | output | AW | Address of the first mismatch |
| err_exp | output | DW | Expected byte at the first mismatch |
| err_act | output | DW | Byte read at the first mismatch |

## Verification
The compare of one read-back falls in the same cycle as the issue of the next command, so stopping and capturing have to win over sequencing in that cycle. The bench provokes this with a behavioural memory that injects stuck data bits, wired-AND data bridges and stuck address bits. It judges the capture against the first failing read, which is derived arithmetically from the fault and the phase order. In the clean runs the last compare coincides with the done pulse. That coincidence is judged by the exact cycle count and by pass rising together with done.

// File: rtl/ramlt_pkg.sv
package ramlt_pkg;
  typedef enum logic [3:0] {
    PH_AWALK0  = 4'd0,
    PH_AWALK1  = 4'd1,
    PH_ARISE   = 4'd2,
    PH_AFALL   = 4'd3,
    PH_BRWR    = 4'd4,
    PH_BRRD    = 4'd5,
    PH_DWALK0  = 4'd6,
    PH_DWALK1  = 4'd7,
    PH_CLR     = 4'd8,
    PH_SET     = 4'd9,
    PH_CLRCHK  = 4'd10,
    PH_TOG     = 4'd11,
    PH_TOGCHK  = 4'd12
  } phase_e;

  typedef enum logic [1:0] {OP_PAIR, OP_WR, OP_RD} opmode_e;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  function automatic opmode_e phase_mode(phase_e p);
    case (p)
      PH_BRWR, PH_CLR, PH_TOG: return OP_WR;
      PH_BRRD, PH_TOGCHK:      return OP_RD;
      default:                 return OP_PAIR;
    endcase
  endfunction
endpackage

// File: rtl/ramlt_pattern.sv
module ramlt_pattern
  import ramlt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int TOG_WRITES = 9,
  parameter int SW = 9
) (
  input  phase_e          phase,
  input  logic [SW-1:0]   step,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   data,
  output opmode_e         mode,
  output logic            last
);
  localparam logic [DW-1:0] PAT_A = {(DW/2){2'b01}};
  localparam int DEPTH = 1 << AW;

  logic [SW-1:0] len;

  always_comb begin
    addr = '0;
    data = '0;
    len  = SW'(1);
    mode = phase_mode(phase);
    case (phase)
      PH_AWALK0: begin addr = ~(AW'(1) << step); data = PAT_A;  len = SW'(AW); end
      PH_AWALK1: begin addr = AW'(1) << step;    data = ~PAT_A; len = SW'(AW); end
      PH_ARISE:  begin addr = step[0] ? '0 : '1; data = PAT_A;  len = SW'(3);  end
      PH_AFALL:  begin addr = '0;                data = ~PAT_A; len = SW'(1);  end
      PH_BRWR, PH_BRRD: begin
        addr = step[AW-1:0];
        data = DW'(step + SW'(1));
        len  = SW'(DEPTH);
      end
      PH_DWALK0: begin data = ~(DW'(1) << step); len = SW'(DW); end
      PH_DWALK1: begin data = DW'(1) << step;    len = SW'(DW); end
      PH_CLR, PH_CLRCHK: begin addr = step[AW-1:0]; data = '0; len = SW'(DEPTH); end
      PH_SET:    begin addr = step[AW-1:0]; data = '1; len = SW'(DEPTH); end
      PH_TOG:    begin data = step[0] ? '1 : '0; len = SW'(TOG_WRITES); end
      PH_TOGCHK: begin data = '0; len = SW'(1); end
      default: ;
    endcase
    last = (step == len - SW'(1));
  end
endmodule

// File: rtl/ramlt_check.sv
module ramlt_check
  import ramlt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          rd_v,
  input  logic [DW-1:0] exp_d,
  input  logic [AW-1:0] rd_addr,
  input  phase_e        rd_phase,
  input  logic [DW-1:0] rdata,
  output logic          mismatch,
  output logic [3:0]    err_phase,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_act
);
  logic          cmp_v;
  logic [DW-1:0] cmp_exp;
  logic [AW-1:0] cmp_addr;
  phase_e        cmp_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_v     <= 1'b0;
      cmp_exp   <= '0;
      cmp_addr  <= '0;
      cmp_phase <= PH_AWALK0;
    end else begin
      cmp_v     <= rd_v;
      cmp_exp   <= exp_d;
      cmp_addr  <= rd_addr;
      cmp_phase <= rd_phase;
    end
  end

  assign mismatch = cmp_v && (rdata != cmp_exp);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_phase <= '0;
      err_addr  <= '0;
      err_exp   <= '0;
      err_act   <= '0;
    end else if (mismatch && arm) begin
      err_phase <= cmp_phase;
      err_addr  <= cmp_addr;
      err_exp   <= cmp_exp;
      err_act   <= rdata;
    end
  end
endmodule

// File: rtl/ram_line_bist.sv
module ram_line_bist
  import ramlt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int TOG_WRITES = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tog_en,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [3:0]    err_phase,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_act
);
  localparam int DEPTH = 1 << AW;
  localparam int LMAX  = (DEPTH > TOG_WRITES) ? ((DEPTH > DW) ? DEPTH : DW)
                                              : ((TOG_WRITES > DW) ? TOG_WRITES : DW);
  localparam int SW    = $clog2(LMAX + 1);

  state_e        st;
  phase_e        phase;
  logic [SW-1:0] step;
  logic          half;
  logic          tog_q;
  logic          drain;
  logic          cmd_rd;
  logic [DW-1:0] cmd_exp;
  phase_e        cmd_phase;

  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  opmode_e       p_mode;
  logic          p_last;
  logic          mismatch;
  logic          final_ph;
  phase_e        nxt_ph;

  ramlt_pattern #(.AW(AW), .DW(DW), .TOG_WRITES(TOG_WRITES), .SW(SW)) u_pat (
    .phase (phase),
    .step  (step),
    .addr  (p_addr),
    .data  (p_data),
    .mode  (p_mode),
    .last  (p_last)
  );

  ramlt_check #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm       (st != S_IDLE),
    .rd_v      (cmd_rd),
    .exp_d     (cmd_exp),
    .rd_addr   (mem_addr),
    .rd_phase  (cmd_phase),
    .rdata     (mem_rdata),
    .mismatch  (mismatch),
    .err_phase (err_phase),
    .err_addr  (err_addr),
    .err_exp   (err_exp),
    .err_act   (err_act)
  );

  assign final_ph = (phase == PH_TOGCHK) || (phase == PH_CLRCHK && !tog_q);
  assign nxt_ph   = phase_e'(phase + 4'd1);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      phase     <= PH_AWALK0;
      step      <= '0;
      half      <= 1'b0;
      tog_q     <= 1'b0;
      drain     <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cmd_rd    <= 1'b0;
      cmd_exp   <= '0;
      cmd_phase <= PH_AWALK0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      cmd_rd <= 1'b0;
      if (mismatch && st != S_IDLE) begin
        st   <= S_IDLE;
        done <= 1'b1;
        pass <= 1'b0;
        fail <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st    <= S_RUN;
            phase <= PH_AWALK0;
            step  <= '0;
            half  <= 1'b0;
            tog_q <= tog_en;
            pass  <= 1'b0;
            fail  <= 1'b0;
          end
          S_RUN: begin
            mem_addr  <= p_addr;
            cmd_exp   <= p_data;
            cmd_phase <= phase;
            if (p_mode == OP_PAIR && !half) begin
              mem_we    <= 1'b1;
              mem_wdata <= p_data;
              half      <= 1'b1;
            end else begin
              if (p_mode == OP_WR) begin
                mem_we    <= 1'b1;
                mem_wdata <= p_data;
              end else begin
                cmd_rd <= 1'b1;
              end
              half <= 1'b0;
              if (p_last) begin
                step <= '0;
                if (final_ph) begin
                  st    <= S_DRAIN;
                  drain <= 1'b0;
                end else begin
                  phase <= nxt_ph;
                end
              end else begin
                step <= step + SW'(1);
              end
            end
          end
          S_DRAIN: begin
            drain <= 1'b1;
            if (drain) begin
              st   <= S_IDLE;
              done <= 1'b1;
              pass <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ramlt_sva.sv
module ramlt_sva #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          mem_we,
  input logic [3:0]    err_phase,
  input logic [AW-1:0] err_addr
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_pass_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(pass) |-> done);

  a_r9_fail_no_pass: assert property (@(posedge clk) disable iff (rst)
    fail |-> !pass);

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we);

  a_r9_capture_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(err_addr) && $stable(err_phase)));
endmodule

bind ram_line_bist ramlt_sva #(.AW(AW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .fail      (fail),
  .mem_we    (mem_we),
  .err_phase (err_phase),
  .err_addr  (err_addr)
);

// File: tb/sim_ram_line_bist.sv
module sim_ram_line_bist;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int TW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int NPAIR = 2*AW + 4 + 2*DW + 2*DEPTH;
  localparam int NCMD  = 2*NPAIR + 3*DEPTH;
  localparam int NWR   = NPAIR + 2*DEPTH;
  localparam int LOGN  = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tog_en = 1'b0;
  logic busy, done, pass, fail, mem_we;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, err_exp, err_act;
  logic [3:0] err_phase;

  int nchk = 0;
  int nfail = 0;
  int fmode = 0;
  int fbit = 0;
  int wn = 0;
  bit finished = 1'b0;
  logic [7:0] ram [DEPTH];
  logic [7:0] wlog_a [LOGN];
  logic [7:0] wlog_d [LOGN];

  always #5 clk = ~clk;

  ram_line_bist #(.AW(AW), .DW(DW), .TOG_WRITES(TW)) u0 (
    .clk(clk), .rst(rst), .start(start), .tog_en(tog_en),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .err_phase(err_phase), .err_addr(err_addr),
    .err_exp(err_exp), .err_act(err_act)
  );

  function automatic logic [7:0] f_addr(input logic [7:0] a);
    case (fmode)
      3: return a | (8'(1) << fbit);
      4: return a & ~(8'(1) << fbit);
      default: return a;
    endcase
  endfunction

  function automatic logic [7:0] f_data(input logic [7:0] d);
    logic [7:0] r;
    logic b;
    r = d;
    if (fmode == 1) r[fbit] = 1'b0;
    if (fmode == 2) begin
      b = d[fbit] & d[fbit+1];
      r[fbit] = b;
      r[fbit+1] = b;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) ram[f_addr(mem_addr)] <= f_data(mem_wdata);
    mem_rdata <= ram[f_addr(mem_addr)];
    if (mem_we) begin
      wlog_a[wn % LOGN] <= mem_addr;
      wlog_d[wn % LOGN] <= mem_wdata;
      wn <= wn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input bit tog, input bit glitch, output int cyc, output int base);
    @(negedge clk);
    tog_en = tog;
    start = 1'b1;
    base = wn;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    tog_en = ~tog;
    cyc = 0;
    while (cyc < 4000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (glitch && cyc == 50) start = 1'b1;
      if (glitch && cyc == 51) start = 1'b0;
      if (done) break;
    end
    if (cyc >= 4000) chk(1'b0, "watchdog run", cyc, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int cyc, b, bad;
    logic [7:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !pass && !fail && !mem_we, "R1 reset",
        {busy, done, pass, fail, mem_we}, 0);
    rst = 1'b0;

    // clean run without burst, with a start pulse while busy (R2)
    run(1'b0, 1'b1, cyc, b);
    chk(cyc == NCMD + 2, "R10 R2 cycle count", cyc, NCMD + 2);
    chk(pass && !fail, "R10 pass", {pass, fail}, 2);
    chk(wn - b == NWR, "R7 write count", wn - b, NWR);
    @(negedge clk);
    chk(!done && !busy, "R10 done pulse width", {done, busy}, 0);
    bad = 0;
    for (int i = 0; i < AW; i++) begin
      if (wlog_a[(b+i)%LOGN] != ~(8'(1) << i) || wlog_d[(b+i)%LOGN] != 8'h55) bad++;
      if (wlog_a[(b+AW+i)%LOGN] != (8'(1) << i) || wlog_d[(b+AW+i)%LOGN] != 8'hAA) bad++;
    end
    chk(bad == 0, "R3 address sweeps", bad, 0);
    bad = 0;
    if (wlog_a[(b+16)%LOGN] != 8'hFF || wlog_a[(b+17)%LOGN] != 8'h00 ||
        wlog_a[(b+18)%LOGN] != 8'hFF || wlog_a[(b+19)%LOGN] != 8'h00) bad++;
    if (wlog_d[(b+16)%LOGN] != 8'h55 || wlog_d[(b+19)%LOGN] != 8'hAA) bad++;
    chk(bad == 0, "R4 address slews", bad, 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (wlog_a[(b+20+i)%LOGN] != 8'(i) || wlog_d[(b+20+i)%LOGN] != 8'(i+1)) bad++;
    chk(bad == 0, "R5 bridge writes", bad, 0);
    bad = 0;
    for (int i = 0; i < DW; i++) begin
      if (wlog_a[(b+276+i)%LOGN] != 8'h00 || wlog_d[(b+276+i)%LOGN] != ~(8'(1) << i)) bad++;
      if (wlog_a[(b+284+i)%LOGN] != 8'h00 || wlog_d[(b+284+i)%LOGN] != (8'(1) << i)) bad++;
    end
    chk(bad == 0, "R6 data sweeps", bad, 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (ram[i] !== 8'h00) bad++;
    chk(bad == 0, "R7 memory cleared", bad, 0);

    // clean run with burst
    run(1'b1, 1'b0, cyc, b);
    chk(cyc == NCMD + TW + 1 + 2, "R8 R10 cycle count burst", cyc, NCMD + TW + 3);
    chk(pass && !fail, "R8 pass burst", {pass, fail}, 2);
    chk(wn - b == NWR + TW, "R8 write count", wn - b, NWR + TW);
    bad = 0;
    for (int i = 0; i < TW; i++)
      if (wlog_a[(b+NWR+i)%LOGN] != 8'h00 ||
          wlog_d[(b+NWR+i)%LOGN] != ((i % 2) ? 8'hFF : 8'h00)) bad++;
    chk(bad == 0, "R8 burst pattern", bad, 0);

    // data stuck-at-0, each bit
    for (int k = 0; k < DW; k++) begin
      fmode = 1; fbit = k;
      run(1'b0, 1'b0, cyc, b);
      if (((8'h55 >> k) & 1) == 1) begin
        e = 8'h55 & ~(8'(1) << k);
        chk(fail && !pass && err_phase == 0 && err_addr == 8'hFE && err_exp == 8'h55 && err_act == e,
            "R9 R11 data stuck0 sweep0", {err_phase, err_addr, err_act}, {4'd0, 8'hFE, e});
      end else begin
        e = 8'hAA & ~(8'(1) << k);
        chk(fail && !pass && err_phase == 1 && err_addr == 8'h01 && err_exp == 8'hAA && err_act == e,
            "R9 data stuck0 sweep1", {err_phase, err_addr, err_act}, {4'd1, 8'h01, e});
      end
    end

    // data wired-AND bridges between neighbours
    for (int k = 0; k < DW - 1; k++) begin
      fmode = 2; fbit = k;
      run(1'b0, 1'b0, cyc, b);
      e = 8'h55 & ~(8'(1) << ((k % 2 == 0) ? k : k + 1));
      chk(fail && err_phase == 0 && err_addr == 8'hFE && err_act == e,
          "R9 data bridge", {err_phase, err_addr, err_act}, {4'd0, 8'hFE, e});
    end

    // address stuck-at-1 and stuck-at-0, each bit: caught by the bridge read
    for (int m = 3; m <= 4; m++) begin
      for (int k = 0; k < AW; k++) begin
        fmode = m; fbit = k;
        run(1'b0, 1'b0, cyc, b);
        e = (8'(1) << k) + 8'd1;
        chk(fail && !pass && err_phase == 5 && err_addr == 8'h00 && err_exp == 8'h01 && err_act == e,
            "R5 R9 address fault", {err_phase, err_addr, err_exp, err_act}, {4'd5, 8'h00, 8'h01, e});
        @(negedge clk);
        chk(!busy && !mem_we && err_act == e, "R9 stop and hold", {busy, mem_we, err_act}, e);
      end
    end

    // fault removed: new start clears fail, run passes
    fmode = 0;
    run(1'b0, 1'b0, cyc, b);
    chk(pass && !fail && cyc == NCMD + 2, "R2 R9 rerun after fail", {pass, fail}, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule